// File: doc/BRIEF.md
# Programmable Polarity Trigger Interrupt

This block watches an active-low external trigger pin and raises an active-low interrupt request towards a processor. Through a small register bus the processor selects one of three modes. In the first, the block fires when the pin is low. In the second, it fires when the pin is high. In the third, it never fires. Firmware alternates between the two level modes to see both edges of the trigger. A falling edge starts a scan, and the matching rising edge stops it.

The pin is brought into the clock domain through a chain of synchronizer flops. When the selected level is present and the block is armed, a one-shot drives the interrupt low for a fixed number of clock cycles. The one-shot then stays spent until the processor writes the mode register again. Because of this the interrupt line can never be held low, even when the trigger sits at the selected level indefinitely. Any write to the mode register, including a rewrite of the same value, rearms the one-shot and cuts short a pulse in progress.

Top module: `trig_irq_ctl`

## Requirements
- R1: After reset `irqN` is 1 and the mode register reads 0 (mode off).
- R2: A write with `busWrEn`=1 at address 0 stores `busWrData[1:0]` as the mode. Address 0 reads back the mode in bits [1:0] with all upper bits 0. A write to any other address changes neither the mode nor the one-shot, and any other address reads as 0.
- R3: In mode 2'b01 with the one-shot armed, a low `trigInN` drives `irqN` low. This happens after the third rising clock edge that follows the pin change: two synchronizer stages, then the one-shot flop.
- R4: In mode 2'b10 with the one-shot armed, a high `trigInN` drives `irqN` low with the same latency. A low pin does not fire in this mode.
- R5: Modes 2'b00 and 2'b11 never drive `irqN` low, whatever the pin does.
- R6: Each interrupt pulse lasts exactly PULSE_LEN clock cycles (default 32) unless a mode write cuts it short.
- R7: After a pulse, `irqN` stays high while the selected level persists or recurs, until the mode register is written.
- R8: A mode write rearms the one-shot, even when the value is unchanged. If the selected level is already present, `irqN` goes low after the second rising edge counted from the write edge.
- R9: A mode write during a pulse returns `irqN` high at the write edge.
- R10: Writing mode 2'b01, then mode 2'b10 after servicing, produces one pulse for the falling edge of `trigInN` and one pulse for the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigInN | input | 1 | Active-low external trigger pin, asynchronous |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach is a mode write that lands while a pulse is running, because a pulse only exists between a synchronized level match and a count that expires on its own. The stimulus first lets a pulse start from a held level. A write then rearms the block, which sets off a second pulse. A few cycles into that second pulse, the bench writes the opposite polarity and checks that the line is released at once and does not fire again. The spent state gets the same treatment: the bench holds the matching level for many cycles and also writes a non-mode address, and checks that neither one refires the one-shot.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

  localparam int MODE_W = 2;

  // Mode field encoding (bits [1:0] of the mode register)
  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_RSVD = 2'b11
  } trigMode_e;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'b00,
    ST_FIRING = 2'b01,
    ST_SPENT  = 2'b10
  } shotState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;
    logic abort;
  } pulseCmd_t;

endpackage

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              pinLevel,
  input  logic              pulseDone,
  output pulseCmd_t         cmd
);

  logic       modeHit;
  logic       modeWr;
  logic       levelMatch;
  trigMode_e  modeQ;
  shotState_e stateQ;
  shotState_e stateD;

  assign modeHit = (busAddr == ADDR_W'(MODE_ADDR));
  assign modeWr  = busWrEn && modeHit;

  // Mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
    end else if (modeWr) begin
      modeQ <= trigMode_e'(busWrData[MODE_W-1:0]);
    end
  end

  // Readback
  always_comb begin
    busRdData = '0;
    if (modeHit) begin
      busRdData[MODE_W-1:0] = modeQ;
    end
  end

  // Level qualification by mode
  always_comb begin
    case (modeQ)
      MODE_LOW:  levelMatch = !pinLevel;
      MODE_HIGH: levelMatch = pinLevel;
      default:   levelMatch = 1'b0;
    endcase
  end

  // One-shot sequencing
  always_comb begin
    stateD    = stateQ;
    cmd       = '0;
    if (modeWr) begin
      stateD    = ST_ARMED;
      cmd.abort = (stateQ == ST_FIRING);
    end else begin
      case (stateQ)
        ST_ARMED: begin
          if (levelMatch) begin
            stateD    = ST_FIRING;
            cmd.start = 1'b1;
          end
        end
        ST_FIRING: begin
          if (pulseDone) begin
            stateD = ST_SPENT;
          end
        end
        ST_SPENT: stateD = ST_SPENT;
        default:  stateD = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ARMED;
    end else begin
      stateQ <= stateD;
    end
  end

  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> (stateQ == ST_ARMED)); // R7

  AST_OFF_NEVER_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFF || modeQ == MODE_RSVD) |-> !cmd.start); // R5

  AST_SPENT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SPENT && !modeWr) |=> (stateQ == ST_SPENT)); // R7

  AST_WRITE_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (stateQ == ST_ARMED || stateQ == ST_FIRING)); // R8

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(modeQ)); // R2

endmodule

// File: rtl/trig_irq_data.sv
module trig_irq_data
  import trig_irq_pkg::*;
#(
  parameter int PULSE_LEN   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigInN,
  input  pulseCmd_t cmd,
  output logic      pinLevel,
  output logic      pulseDone,
  output logic      irqN
);

  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   activeQ;
  logic [CNT_W-1:0]       cntQ;

  // Synchronizer chain; idle level of the pin is high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[g] <= 1'b1;
      end else if (g == 0) begin
        syncQ[g] <= trigInN;
      end else begin
        syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];

  // Pulse timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end else if (cmd.start) begin
      activeQ <= 1'b1;
      cntQ    <= CNT_LOAD;
    end else if (activeQ) begin
      if (cmd.abort || cntQ == '0) begin
        activeQ <= 1'b0;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign pulseDone = activeQ && (cntQ == '0);
  assign irqN      = !activeQ;

  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |=> (!irqN && cntQ == CNT_LOAD)); // R6

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && cntQ == '0 && !cmd.start) |=> irqN); // R6

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !cmd.abort && !cmd.start && cntQ != '0)
      |=> (!irqN && cntQ == CNT_W'($past(cntQ) - 1'b1))); // R6

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.abort && !cmd.start) |=> irqN); // R9

  AST_IDLE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (irqN && !cmd.start) |=> irqN); // R3

endmodule

// File: rtl/trig_irq_ctl.sv
module trig_irq_ctl
  import trig_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int MODE_ADDR   = 0,
  parameter int PULSE_LEN   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigInN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqN
);

  pulseCmd_t cmd;
  logic      pinLevel;
  logic      pulseDone;

  trig_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_ADDR (MODE_ADDR)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinLevel  (pinLevel),
    .pulseDone (pulseDone),
    .cmd       (cmd)
  );

  trig_irq_data #(
    .PULSE_LEN   (PULSE_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .trigInN   (trigInN),
    .cmd       (cmd),
    .pinLevel  (pinLevel),
    .pulseDone (pulseDone),
    .irqN      (irqN)
  );

endmodule

// File: tb/sim_trig_irq_ctl.sv
`timescale 1ns/1ps
module sim_trig_irq_ctl;

  localparam int PLEN = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigInN = 1'b1;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_irq_ctl u0 (
    .clk(clk), .rstN(rstN), .trigInN(trigInN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqN(irqN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  // Expects irqN high for n negedges
  task automatic expect_high(input string req, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!irqN) lows++;
    end
    check(req, lows, 0);
  endtask

  // irqN currently low: count remaining low cycles including this one
  task automatic measure_low(output int len);
    len = 0;
    while (!irqN && len < 4 * PLEN) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0; trigInN = 1'b1;
    wait_n(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqN after reset", irqN, 1);
    busAddr = 4'd0; #0.1;
    check("R1 mode after reset", busRdData, 0);
  endtask

  task automatic t_bus;
    int len;
    trigInN = 1'b1;
    bus_write(4'd0, 8'hFE);
    busAddr = 4'd0; #0.1;
    check("R2 readback masked", busRdData, 2);
    @(negedge clk);
    check("R8 fire after write", irqN, 0);
    measure_low(len);
    bus_write(4'd3, 8'h01);
    busAddr = 4'd0; #0.1;
    check("R2 mode unchanged by other addr", busRdData, 2);
    busAddr = 4'd3; #0.1;
    check("R2 other addr reads zero", busRdData, 0);
    busAddr = 4'd0;
    expect_high("R2 other addr no rearm", 10);
  endtask

  task automatic t_low_edge_and_pulse;
    int len;
    trigInN = 1'b1;
    bus_write(4'd0, 8'h01);
    expect_high("R3 no fire on high pin", 5);
    trigInN = 1'b0;
    @(negedge clk);
    check("R3 latency edge1", irqN, 1);
    @(negedge clk);
    check("R3 latency edge2", irqN, 1);
    @(negedge clk);
    check("R3 low after third edge", irqN, 0);
    measure_low(len);
    check("R6 pulse width", len, PLEN);
    expect_high("R7 no refire while low held", 60);
  endtask

  task automatic t_rearm_and_abort;
    int len;
    bus_write(4'd0, 8'h01);
    check("R8 not yet low at write edge", irqN, 1);
    @(negedge clk);
    check("R8 rearm fires same value", irqN, 0);
    wait_n(5);
    check("R9 still low mid pulse", irqN, 0);
    bus_write(4'd0, 8'h02);
    check("R9 released at write edge", irqN, 1);
    expect_high("R4 low pin ignored in high mode", 40);
  endtask

  task automatic t_high_edge;
    int len;
    trigInN = 1'b1;
    wait_n(2);
    check("R4 latency edge2", irqN, 1);
    @(negedge clk);
    check("R4 fire on high pin", irqN, 0);
    measure_low(len);
    check("R6 high pulse width", len, PLEN);
  endtask

  task automatic t_disabled;
    bus_write(4'd0, 8'h00);
    trigInN = 1'b0; expect_high("R5 mode 00 low pin", 10);
    trigInN = 1'b1; expect_high("R5 mode 00 high pin", 10);
    bus_write(4'd0, 8'h03);
    trigInN = 1'b0; expect_high("R5 mode 11 low pin", 10);
    trigInN = 1'b1; expect_high("R5 mode 11 high pin", 10);
  endtask

  task automatic t_scan_sequence;
    int len;
    int pulses = 0;
    trigInN = 1'b1;
    bus_write(4'd0, 8'h01);
    wait_n(4);
    trigInN = 1'b0;
    wait_n(3);
    if (!irqN) pulses++;
    measure_low(len);
    bus_write(4'd0, 8'h02);
    expect_high("R10 quiet between edges", 20);
    trigInN = 1'b1;
    wait_n(3);
    if (!irqN) pulses++;
    measure_low(len);
    check("R10 start and stop pulses", pulses, 2);
  endtask

  initial begin
    t_reset();
    t_bus();
    t_low_edge_and_pulse();
    t_rearm_and_abort();
    t_high_edge();
    t_disabled();
    t_scan_sequence();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule